// File: doc/BRIEF.md
# Iterative Early-Out Word Multiplier

This block computes the low word of the product of two unsigned or two's-complement operands over several clock cycles, using a narrow partial-product array. A start strobe loads the two operands. One operand is kept whole as the multiplicand. The other is consumed one slice at a time, starting from the least significant slice. In each cycle the array multiplies the current slice by the multiplicand, which has already been shifted into position. That partial product is added to a running sum that wraps at the word width.

Before each further cycle the block inspects the slices of the sliced operand that have not yet been processed. If they are all zero, nothing more can reach the product, so the block stops and presents the result. A small value of the sliced operand therefore finishes quickly. Callers that can choose which operand is sliced should feed the smaller one to that port.

Top module: `mul_early_out`

## Requirements
- R1: When `done` is high, `result` equals (`op_a` × `op_b`) mod 2^DATA_W, using the operands captured at the accepted start.
- R2: Operands holding two's-complement negative values give the low word of their signed product, with no extra control.
- R3: Let k be the index of the highest nonzero SLICE_W-bit slice of `op_b` (slice 0 is bits SLICE_W-1:0). `done` rises exactly k+1 clock edges after the edge that accepts the start. An `op_b` of zero, or one below 2^SLICE_W, takes one edge.
- R4: `done` is high for exactly one cycle per operation. `result` changes only on the edge that raises `done`, and it then holds until the next completion.
- R5: `busy` is high from the edge that accepts a start up to the edge that raises `done`, and it is low while `done` is high.
- R6: A `start` seen while `busy` is high is ignored. The running operation keeps its original operands and its latency.
- R7: A synchronous active-high `rst` drives `busy` and `done` low and `result` to zero.
- R8: A `start` given in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load operands and begin; honoured only while idle |
| op_a | input | DATA_W | Multiplicand, used whole |
| op_b | input | DATA_W | Multiplier, consumed slice by slice |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Low word of the product, held between operations |

## Verification
The bench uses the default parameters: a 32-bit word and an 8-bit slice, which gives four slices. With these values every latency from one to four cycles can be reached just by choosing where the top nonzero byte of `op_b` sits. Both the early stop after the first slice and the full four-slice run, including the wrap of the sum, are therefore covered. Signed and unsigned operands share the same path, so negative operands check the same datapath against a signed reference product.

// File: rtl/mul_eo_pkg.sv
package mul_eo_pkg;
  localparam int DEF_DATA_W  = 32;
  localparam int DEF_SLICE_W = 8;

  // number of slices needed to cover a word
  function automatic int slices_of(input int data_w, input int slice_w);
    return (data_w + slice_w - 1) / slice_w;
  endfunction
endpackage

// File: rtl/mul_eo_slice_mult.sv
// Narrow array: slice (SLICE_W bits) times multiplicand (DATA_W bits), low word kept.
module mul_eo_slice_mult #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0]  mcand,
  input  logic [SLICE_W-1:0] slice,
  output logic [DATA_W-1:0]  prod
);
  logic [DATA_W-1:0] row [SLICE_W];

  generate
    for (genvar j = 0; j < SLICE_W; j++) begin : g_row
      assign row[j] = slice[j] ? (mcand << j) : '0;
    end
  endgenerate

  always_comb begin
    prod = '0;
    for (int j = 0; j < SLICE_W; j++) begin
      prod = prod + row[j];
    end
  end
endmodule

// File: rtl/mul_eo_zero_detect.sv
// Flags that the remaining, unprocessed multiplier bits are all zero.
module mul_eo_zero_detect #(
  parameter int W = 24
) (
  input  logic [W-1:0] bits_in,
  output logic         all_zero
);
  assign all_zero = ~|bits_in;
endmodule

// File: rtl/mul_early_out.sv
module mul_early_out
  import mul_eo_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int SLICE_W = DEF_SLICE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int UPPER_W = DATA_W - SLICE_W;

  logic [DATA_W-1:0] mcand_q;   // multiplicand pre-shifted to the current slice weight
  logic [DATA_W-1:0] rem_q;     // multiplier bits still to process, current slice at bottom
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] res_q;
  logic              busy_q;
  logic              done_q;

  logic [DATA_W-1:0] pp;
  logic [DATA_W-1:0] acc_nx;
  logic              last_slice;

  mul_eo_slice_mult #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_arr (
    .mcand (mcand_q),
    .slice (rem_q[SLICE_W-1:0]),
    .prod  (pp)
  );

  mul_eo_zero_detect #(.W(UPPER_W)) u_zd (
    .bits_in  (rem_q[DATA_W-1:SLICE_W]),
    .all_zero (last_slice)
  );

  assign acc_nx = acc_q + pp;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      rem_q   <= '0;
      acc_q   <= '0;
      res_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          mcand_q <= op_a;
          rem_q   <= op_b;
          acc_q   <= '0;
          busy_q  <= 1'b1;
        end
      end else begin
        acc_q   <= acc_nx;
        mcand_q <= mcand_q << SLICE_W;
        rem_q   <= rem_q >> SLICE_W;
        if (last_slice) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= acc_nx;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/mul_eo_chk.sv
module mul_eo_chk #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result
);
  localparam int NSL = (DATA_W + SLICE_W - 1) / SLICE_W;

  logic [DATA_W-1:0] ref_prod;
  logic [7:0]        ref_n;
  logic [7:0]        cyc;

  function automatic logic [7:0] need(input logic [DATA_W-1:0] b);
    logic [7:0] n;
    n = 8'd1;
    for (int i = 1; i < NSL; i++) begin
      if (((b >> (i * SLICE_W)) & {{(DATA_W-SLICE_W){1'b0}}, {SLICE_W{1'b1}}}) != '0)
        n = 8'(i + 1);
    end
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prod <= '0;
      ref_n    <= 8'd1;
      cyc      <= '0;
    end else if (start && !busy) begin
      ref_prod <= op_a * op_b;
      ref_n    <= need(op_b);
      cyc      <= '0;
    end else if (busy) begin
      cyc <= cyc + 8'd1;
    end
  end

  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    done |-> result == ref_prod);
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> cyc == ref_n);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);
  a_r5_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc + 8'd1 < ref_n) |=> busy);
endmodule

bind mul_early_out mul_eo_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
  .busy(busy), .done(done), .result(result)
);

// File: tb/mul_early_out_test.sv
module mul_early_out_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h1234_5678, 32'h0000_00FF},
    {32'h1234_5678, 32'h0000_0100},
    {32'hDEAD_BEEF, 32'h0000_FFFF},
    {32'hCAFE_F00D, 32'h0001_0000},
    {32'h0000_0007, 32'h00FF_0000},
    {32'h89AB_CDEF, 32'h0100_0000},
    {32'hFFFF_FFFF, 32'h8000_0001}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic          busy, done;
  logic [DW-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_early_out uut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result)
  );

  function automatic int exp_n(input logic [DW-1:0] b);
    int n = 1;
    for (int i = 1; i < 4; i++) if (b[i*8 +: 8] != 8'h00) n = i + 1;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after the start edge
  task automatic issue(input logic [DW-1:0] a, input logic [DW-1:0] b);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // call at the negedge after the start edge; returns at the negedge where done is high
  task automatic finish_op(input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag);
    int cnt = 0;
    logic [DW-1:0] expv = a * b;
    check(busy == 1'b1, "R5 busy after start", 64'(busy), 64'd1);
    while (!done && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    check(done == 1'b1, {"R4 done seen ", tag}, 64'(done), 64'd1);
    check(result == expv, {"R1 product ", tag}, 64'(result), 64'(expv));
    check(cnt == exp_n(b), {"R3 latency ", tag}, 64'(cnt), 64'(exp_n(b)));
    check(busy == 1'b0, "R5 idle at done", 64'(busy), 64'd0);
  endtask

  task automatic after_done(input logic [DW-1:0] held);
    @(negedge clk);
    check(done == 1'b0, "R4 single pulse", 64'(done), 64'd0);
    check(result == held, "R4 result held", 64'(result), 64'(held));
  endtask

  initial begin
    logic [DW-1:0] a, b;
    logic signed [DW-1:0] sa, sb;
    logic signed [DW-1:0] sp;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R7 reset flags", {busy, done}, 0);
    check(result == '0, "R7 reset result", 64'(result), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      a = VEC[i][63:32]; b = VEC[i][31:0];
      issue(a, b);
      finish_op(a, b, "table");
      after_done(a * b);
    end

    for (int i = 0; i < 40; i++) begin
      a = $urandom;
      b = $urandom >> (8 * (i % 4));
      issue(a, b);
      finish_op(a, b, "random");
      after_done(a * b);
    end

    // R2 signed operands
    sa = -32'sd12345; sb = 32'sd7;
    sp = sa * sb;
    issue(sa, sb);
    finish_op(sa, sb, "signed");
    check(result == sp, "R2 signed neg*pos", 64'(result), 64'(sp));
    after_done(sp);
    sa = -32'sd3; sb = -32'sd1000;
    sp = sa * sb;
    issue(sa, sb);
    finish_op(sa, sb, "signed");
    check(result == sp, "R2 signed neg*neg", 64'(result), 64'(sp));
    after_done(sp);

    // R6 start while busy ignored
    op_a = 32'h0000_0003; op_b = 32'h0102_0304; start = 1'b1;
    @(negedge clk);
    op_a = 32'h5555_5555; op_b = 32'h0000_0009;
    @(negedge clk);
    start = 1'b0;
    begin
      int cnt = 1;
      while (!done && cnt < 10) begin
        @(negedge clk);
        cnt++;
      end
      check(result == 32'h0306_090C, "R6 original operands kept", 64'(result), 64'h0306_090C);
      check(cnt == 4, "R6 latency unchanged", 64'(cnt), 64'd4);
    end

    // R8 back to back: start in the done cycle
    issue(32'h0000_0010, 32'h0000_0020);
    check(1'b1, "R8 setup", 0, 0);
    while (!done) @(negedge clk);
    issue(32'h0000_1000, 32'h0000_0300);
    finish_op(32'h0000_1000, 32'h0000_0300, "R8 back-to-back");
    after_done(32'h0030_0000);

    // R7 reset mid-operation
    issue(32'hFFFF_FFFF, 32'hFF00_0000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0 && done == 1'b0 && result == '0, "R7 reset mid-op",
          {busy, done, result}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule